// File: doc/BRIEF.md
# Slot Hotplug Event Controller

This block tracks insertion and removal notifications for up to 32 slots on one bus and presents them to system software through a small register window. A platform agent reports each slot event on a slot-number input together with a two-bit kind code. The controller keeps the most recent event as a single set bit in either an insertion vector or a removal vector, and raises a general-purpose event status flag. When the matching enable flag is also set, an event-pending output tells the interrupt logic that software attention is needed.

Software acknowledges an event by writing ones to the status flag. It reads the two vectors to find the affected slot. To request the removal of a device it writes a slot mask to an eject register. The controller picks the lowest set bit of that mask and emits a single-cycle eject strobe with the slot number, unless that slot is marked as fixed. A static fixed-slot mask is captured while reset is held, and a read-only removability register reports its complement.

All register accesses are single-cycle: read data is combinational on the request, and writes take effect at the next rising clock edge. The reset is synchronous and active low.

Top module: `hp_event_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the insertion vector, removal vector, all status and enable bytes, `evt_pending` and `eject_pulse` become zero.
- R2: The insertion vector (offset 0x00) and removal vector (offset 0x04) are 32-bit read/write registers. A write with `req_wdata` takes effect at the next edge and reads back unchanged.
- R3: A hot insertion (`hp_kind` = 2'b01) clears both vectors, then sets bit `hp_slot` of the insertion vector and bit 1 of status byte 0, all at the same edge.
- R4: A removal (`hp_kind` = 2'b10) clears both vectors, then sets bit `hp_slot` of the removal vector and bit 1 of status byte 0, all at the same edge.
- R5: A cold insertion (`hp_kind` = 2'b00) and the reserved code 2'b11 change neither vector nor any status bit.
- R6: A write to the eject register (offset 0x08) with a nonzero value produces `eject_pulse` high for exactly the cycle after the write edge, with `eject_slot` equal to the index of the lowest set bit. A zero value produces no strobe, and reads of offset 0x08 return zero.
- R7: If the lowest set bit of an eject write names a fixed slot, no strobe is produced, even when higher bits name removable slots.
- R8: The removability register (offset 0x0C) reads as the bitwise complement of `fixed_slots` as captured during reset. Writes to it are ignored, and changes to `fixed_slots` after reset have no effect on it or on ejection.
- R9: The event block occupies byte offsets 0x10 to 0x13: status byte 0, status byte 1, enable byte 0, enable byte 1. It uses `req_wdata[7:0]` and `rd_data[7:0]` with the upper read bits zero. Status bytes are write-one-to-clear, and enable bytes are plain read/write.
- R10: `evt_pending` is high exactly when bit 1 of status byte 0 and bit 1 of enable byte 0 are both set, following any write or event at the next edge.
- R11: When a hot insertion or removal coincides with a software write to a vector, or with a write-one-to-clear of status bit 1, the event wins: the vectors hold only the new slot bit and status bit 1 ends set.
- R12: Offsets outside the map read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset; `fixed_slots` is captured while it is low |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte offset inside the window |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid in the cycle of a read request |
| hp_valid | input | 1 | Slot event strobe |
| hp_kind | input | 2 | 00 cold insert, 01 hot insert, 10 removal, 11 reserved |
| hp_slot | input | 5 | Slot number of the event |
| fixed_slots | input | 32 | Static mask of slots that cannot be ejected |
| evt_pending | output | 1 | Event pending to software |
| eject_pulse | output | 1 | One-cycle eject request |
| eject_slot | output | 5 | Slot number for the eject request |

## Verification
The hardest situation to reach from the ports is a collision: a slot event arriving in the same cycle as a software write to a vector, or as the acknowledge write to status bit 1. The stimulus task therefore drives the register request and the event strobe together in one clock. The reference model then has to decide the winner on its own. Eject masks whose lowest bit is a fixed slot while higher bits are removable check that the slot picker does not fall back to another bit. Changing `fixed_slots` after reset confirms that only the captured value counts.

// File: rtl/hp_evt_pkg.sv
package hp_evt_pkg;

   typedef enum logic [1:0] {
      HP_COLD_IN = 2'b00,
      HP_HOT_IN  = 2'b01,
      HP_REMOVE  = 2'b10,
      HP_RSVD    = 2'b11
   } hp_kind_e;

   // byte offsets inside the register window
   localparam int OFS_UP    = 'h00;
   localparam int OFS_DOWN  = 'h04;
   localparam int OFS_EJECT = 'h08;
   localparam int OFS_RMV   = 'h0C;
   localparam int OFS_GPE   = 'h10;

   // lowest-set-bit finder variants
   localparam int FIND_SCAN    = 0;
   localparam int FIND_ISOLATE = 1;

endpackage

// File: rtl/hp_slot_vectors.sv
module hp_slot_vectors #(
   parameter int NUM_SLOTS = 32,
   parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ev_valid,
   input  logic                 ev_is_insert,
   input  logic [SLOT_W-1:0]    ev_slot,
   input  logic                 sw_up_we,
   input  logic                 sw_down_we,
   input  logic [NUM_SLOTS-1:0] sw_data,
   output logic [NUM_SLOTS-1:0] up_q,
   output logic [NUM_SLOTS-1:0] down_q
);

   localparam logic [NUM_SLOTS-1:0] ONE = {{(NUM_SLOTS-1){1'b0}}, 1'b1};

   logic [NUM_SLOTS-1:0] slot_bit;

   assign slot_bit = ONE << ev_slot;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         up_q   <= '0;
         down_q <= '0;
      end else if (ev_valid) begin
         // an event wipes both vectors and leaves only its own slot bit
         up_q   <= ev_is_insert ? slot_bit : '0;
         down_q <= ev_is_insert ? '0 : slot_bit;
      end else begin
         if (sw_up_we)   up_q   <= sw_data;
         if (sw_down_we) down_q <= sw_data;
      end
   end

endmodule

// File: rtl/hp_eject_unit.sv
module hp_eject_unit #(
   parameter int NUM_SLOTS = 32,
   parameter int SLOT_W    = $clog2(NUM_SLOTS),
   parameter int FINDER    = hp_evt_pkg::FIND_ISOLATE
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [NUM_SLOTS-1:0] wr_mask,
   input  logic [NUM_SLOTS-1:0] fixed_mask,
   output logic                 pulse_q,
   output logic [SLOT_W-1:0]    slot_q
);

   logic [SLOT_W-1:0] low_idx;
   logic              any_set;

   assign any_set = |wr_mask;

   generate
      if (FINDER == hp_evt_pkg::FIND_SCAN) begin : g_scan
         always_comb begin
            low_idx = '0;
            for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
               if (wr_mask[i]) low_idx = SLOT_W'(i);
            end
         end
      end else begin : g_isolate
         logic [NUM_SLOTS-1:0] iso;
         assign iso = wr_mask & (~wr_mask + {{(NUM_SLOTS-1){1'b0}}, 1'b1});
         for (genvar b = 0; b < SLOT_W; b++) begin : g_bit
            logic acc;
            always_comb begin
               acc = 1'b0;
               for (int i = 0; i < NUM_SLOTS; i++) begin
                  if (((i >> b) & 1) == 1) acc = acc | iso[i];
               end
            end
            assign low_idx[b] = acc;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pulse_q <= 1'b0;
         slot_q  <= '0;
      end else begin
         pulse_q <= wr_en && any_set && !fixed_mask[low_idx];
         if (wr_en && any_set) slot_q <= low_idx;
      end
   end

endmodule

// File: rtl/hp_gpe_block.sv
module hp_gpe_block #(
   parameter int HALF   = 2,
   parameter int HP_BIT = 1,
   parameter int IDX_W  = $clog2(2 * HALF)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [7:0]        wr_byte,
   input  logic              set_hp,
   output logic [HALF*8-1:0] sts_q,
   output logic [HALF*8-1:0] en_q,
   output logic              pending
);

   localparam int HP_BYTE = HP_BIT / 8;
   localparam int HP_POS  = HP_BIT % 8;

   generate
      if (HP_BIT >= HALF * 8) begin : g_bad_bit
         $error("hp_gpe_block: HP_BIT outside the status bytes");
      end

      for (genvar i = 0; i < HALF; i++) begin : g_byte
         logic [7:0] sts_nxt;

         always_comb begin
            sts_nxt = sts_q[i*8 +: 8];
            if (wr_en && wr_idx == IDX_W'(i)) sts_nxt = sts_nxt & ~wr_byte;
            if (set_hp && i == HP_BYTE) sts_nxt[HP_POS] = 1'b1;
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sts_q[i*8 +: 8] <= '0;
               en_q[i*8 +: 8]  <= '0;
            end else begin
               sts_q[i*8 +: 8] <= sts_nxt;
               if (wr_en && wr_idx == IDX_W'(HALF + i)) en_q[i*8 +: 8] <= wr_byte;
            end
         end
      end
   endgenerate

   assign pending = sts_q[HP_BIT] & en_q[HP_BIT];

endmodule

// File: rtl/hp_event_ctrl.sv
module hp_event_ctrl #(
   parameter int NUM_SLOTS = 32,
   parameter int SLOT_W    = $clog2(NUM_SLOTS),
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 5,
   parameter int GPE_HALF  = 2,
   parameter int HP_BIT    = 1,
   parameter int FINDER    = hp_evt_pkg::FIND_ISOLATE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rd_data,
   input  logic              hp_valid,
   input  logic [1:0]        hp_kind,
   input  logic [SLOT_W-1:0] hp_slot,
   input  logic [NUM_SLOTS-1:0] fixed_slots,
   output logic              evt_pending,
   output logic              eject_pulse,
   output logic [SLOT_W-1:0] eject_slot
);
   import hp_evt_pkg::*;

   localparam int GPE_BYTES = 2 * GPE_HALF;
   localparam int IDX_W     = $clog2(GPE_BYTES);

   generate
      if (NUM_SLOTS > DATA_W) begin : g_bad_slots
         $error("hp_event_ctrl: NUM_SLOTS exceeds DATA_W");
      end
      if (OFS_GPE + GPE_BYTES > (1 << ADDR_W)) begin : g_bad_addr
         $error("hp_event_ctrl: event block does not fit the address space");
      end
      if ((1 << SLOT_W) < NUM_SLOTS) begin : g_bad_slot_w
         $error("hp_event_ctrl: SLOT_W too narrow");
      end
   endgenerate

   logic                 wr_acc, rd_acc;
   logic                 ev_valid, ev_is_insert;
   logic                 in_gpe;
   logic [IDX_W-1:0]     gpe_idx;
   logic [NUM_SLOTS-1:0] fixed_q;
   logic [NUM_SLOTS-1:0] up_vec, down_vec;
   logic [GPE_HALF*8-1:0] gpe_sts_q, gpe_en_q;
   logic [GPE_BYTES*8-1:0] gpe_all;

   assign wr_acc       = req_valid && req_write;
   assign rd_acc       = req_valid && !req_write;
   assign ev_valid     = hp_valid && (hp_kind_e'(hp_kind) == HP_HOT_IN ||
                                      hp_kind_e'(hp_kind) == HP_REMOVE);
   assign ev_is_insert = hp_kind_e'(hp_kind) == HP_HOT_IN;
   assign in_gpe       = req_addr >= ADDR_W'(OFS_GPE) &&
                         req_addr <  ADDR_W'(OFS_GPE + GPE_BYTES);
   assign gpe_idx      = IDX_W'(req_addr - ADDR_W'(OFS_GPE));
   assign gpe_all      = {gpe_en_q, gpe_sts_q};

   // fixed-slot mask is captured only while reset is held
   always_ff @(posedge clk) begin
      if (!rst_n) fixed_q <= fixed_slots;
   end

   hp_slot_vectors #(
      .NUM_SLOTS (NUM_SLOTS),
      .SLOT_W    (SLOT_W)
   ) u_vec (
      .clk          (clk),
      .rst_n        (rst_n),
      .ev_valid     (ev_valid),
      .ev_is_insert (ev_is_insert),
      .ev_slot      (hp_slot),
      .sw_up_we     (wr_acc && req_addr == ADDR_W'(OFS_UP)),
      .sw_down_we   (wr_acc && req_addr == ADDR_W'(OFS_DOWN)),
      .sw_data      (req_wdata[NUM_SLOTS-1:0]),
      .up_q         (up_vec),
      .down_q       (down_vec)
   );

   hp_eject_unit #(
      .NUM_SLOTS (NUM_SLOTS),
      .SLOT_W    (SLOT_W),
      .FINDER    (FINDER)
   ) u_eject (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_acc && req_addr == ADDR_W'(OFS_EJECT)),
      .wr_mask    (req_wdata[NUM_SLOTS-1:0]),
      .fixed_mask (fixed_q),
      .pulse_q    (eject_pulse),
      .slot_q     (eject_slot)
   );

   hp_gpe_block #(
      .HALF   (GPE_HALF),
      .HP_BIT (HP_BIT),
      .IDX_W  (IDX_W)
   ) u_gpe (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_acc && in_gpe),
      .wr_idx  (gpe_idx),
      .wr_byte (req_wdata[7:0]),
      .set_hp  (ev_valid),
      .sts_q   (gpe_sts_q),
      .en_q    (gpe_en_q),
      .pending (evt_pending)
   );

   always_comb begin
      rd_data = '0;
      if (rd_acc) begin
         if (req_addr == ADDR_W'(OFS_UP))
            rd_data[NUM_SLOTS-1:0] = up_vec;
         else if (req_addr == ADDR_W'(OFS_DOWN))
            rd_data[NUM_SLOTS-1:0] = down_vec;
         else if (req_addr == ADDR_W'(OFS_RMV))
            rd_data[NUM_SLOTS-1:0] = ~fixed_q;
         else if (in_gpe)
            rd_data[7:0] = gpe_all[gpe_idx*8 +: 8];
      end
   end

endmodule

// File: rtl/hp_event_ctrl_chk.sv
module hp_event_ctrl_chk #(
   parameter int NUM_SLOTS = 32,
   parameter int SLOT_W    = 5,
   parameter int ADDR_W    = 5,
   parameter int GPE_HALF  = 2,
   parameter int HP_BIT    = 1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  req_valid,
   input logic                  req_write,
   input logic [ADDR_W-1:0]     req_addr,
   input logic                  hp_valid,
   input logic [1:0]            hp_kind,
   input logic [SLOT_W-1:0]     hp_slot,
   input logic                  evt_pending,
   input logic                  eject_pulse,
   input logic [SLOT_W-1:0]     eject_slot,
   input logic [NUM_SLOTS-1:0]  up_vec,
   input logic [NUM_SLOTS-1:0]  down_vec,
   input logic [GPE_HALF*8-1:0] gpe_sts_q,
   input logic [NUM_SLOTS-1:0]  fixed_q
);
   localparam logic [NUM_SLOTS-1:0] ONE = {{(NUM_SLOTS-1){1'b0}}, 1'b1};

   p_insert_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hp_valid && hp_kind == 2'b01) |=>
         (up_vec == (ONE << $past(hp_slot))) && (down_vec == '0) && gpe_sts_q[HP_BIT]);

   p_remove_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hp_valid && hp_kind == 2'b10) |=>
         (down_vec == (ONE << $past(hp_slot))) && (up_vec == '0) && gpe_sts_q[HP_BIT]);

   p_cold_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hp_valid && (hp_kind == 2'b00 || hp_kind == 2'b11) && !(req_valid && req_write)) |=>
         ($stable(up_vec) && $stable(down_vec)));

   p_eject_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      eject_pulse |-> $past(req_valid && req_write && req_addr == ADDR_W'('h08)));

   p_eject_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      eject_pulse |-> !fixed_q[eject_slot]);

   p_fixed_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> $stable(fixed_q));

   p_pending_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt_pending) |-> $past(hp_valid || (req_valid && req_write)));

endmodule

bind hp_event_ctrl hp_event_ctrl_chk #(
   .NUM_SLOTS (NUM_SLOTS),
   .SLOT_W    (SLOT_W),
   .ADDR_W    (ADDR_W),
   .GPE_HALF  (GPE_HALF),
   .HP_BIT    (HP_BIT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_write   (req_write),
   .req_addr    (req_addr),
   .hp_valid    (hp_valid),
   .hp_kind     (hp_kind),
   .hp_slot     (hp_slot),
   .evt_pending (evt_pending),
   .eject_pulse (eject_pulse),
   .eject_slot  (eject_slot),
   .up_vec      (up_vec),
   .down_vec    (down_vec),
   .gpe_sts_q   (gpe_sts_q),
   .fixed_q     (fixed_q)
);

// File: tb/hp_event_ctrl_test.sv
module hp_event_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [4:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] rd_data;
   logic        hp_valid = 1'b0;
   logic [1:0]  hp_kind = '0;
   logic [4:0]  hp_slot = '0;
   logic [31:0] fixed_slots = 32'h0000_0104;
   logic        evt_pending;
   logic        eject_pulse;
   logic [4:0]  eject_slot;

   int checks = 0;
   int errors = 0;
   string cur_req = "R1";

   // reference model state
   bit [31:0] m_up, m_down, m_fixed;
   bit [7:0]  m_sts [2];
   bit [7:0]  m_en  [2];
   bit        m_pulse;
   int        m_slot;

   always #5 clk = ~clk;

   hp_event_ctrl uut (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_write (req_write),
      .req_addr (req_addr), .req_wdata (req_wdata), .rd_data (rd_data),
      .hp_valid (hp_valid), .hp_kind (hp_kind), .hp_slot (hp_slot),
      .fixed_slots (fixed_slots), .evt_pending (evt_pending),
      .eject_pulse (eject_pulse), .eject_slot (eject_slot)
   );

   task automatic check(string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", cur_req, what, act, exp);
      end
   endtask

   function automatic bit [31:0] model_read(int a);
      case (a)
         'h00: return m_up;
         'h04: return m_down;
         'h0C: return ~m_fixed;
         'h10: return {24'h0, m_sts[0]};
         'h11: return {24'h0, m_sts[1]};
         'h12: return {24'h0, m_en[0]};
         'h13: return {24'h0, m_en[1]};
         default: return 32'h0;
      endcase
   endfunction

   task automatic model_edge(bit v, bit w, int a, bit [31:0] d, bit hv, int hk, int hs, bit rn, bit [31:0] fx);
      bit ev;
      if (!rn) begin
         m_up = 0; m_down = 0; m_sts[0] = 0; m_sts[1] = 0;
         m_en[0] = 0; m_en[1] = 0; m_pulse = 0; m_fixed = fx;
         return;
      end
      ev = hv && (hk == 1 || hk == 2);
      m_pulse = 0;
      if (v && w) begin
         if (!ev && a == 'h00) m_up = d;
         if (!ev && a == 'h04) m_down = d;
         if (a == 'h10) m_sts[0] &= ~d[7:0];
         if (a == 'h11) m_sts[1] &= ~d[7:0];
         if (a == 'h12) m_en[0] = d[7:0];
         if (a == 'h13) m_en[1] = d[7:0];
         if (a == 'h08 && d != 0) begin
            int low = 0;
            for (int i = 31; i >= 0; i--) if (d[i]) low = i;
            m_slot = low;
            m_pulse = !m_fixed[low];
         end
      end
      if (ev) begin
         m_up = 0; m_down = 0;
         if (hk == 1) m_up[hs] = 1'b1; else m_down[hs] = 1'b1;
         m_sts[0][1] = 1'b1;
      end
   endtask

   // one clock: inputs set at the falling edge, model steps at the rising edge,
   // outputs compared at the next falling edge
   task automatic cycle(bit v, bit w, int a, bit [31:0] d, bit hv, int hk, int hs);
      req_valid = v; req_write = w; req_addr = 5'(a); req_wdata = d;
      hp_valid = hv; hp_kind = 2'(hk); hp_slot = 5'(hs);
      #1;
      if (v && !w) check($sformatf("read 0x%0h", a), rd_data, model_read(a));
      @(posedge clk);
      model_edge(v, w, a, d, hv, hk, hs, rst_n, fixed_slots);
      @(negedge clk);
      req_valid = 0; req_write = 0; hp_valid = 0;
      check("evt_pending", evt_pending, m_sts[0][1] & m_en[0][1]);
      check("eject_pulse", eject_pulse, m_pulse);
      if (m_pulse) check("eject_slot", eject_slot, m_slot);
   endtask

   task automatic wr(int a, bit [31:0] d);  cycle(1, 1, a, d, 0, 0, 0); endtask
   task automatic rd(int a);                cycle(1, 0, a, 0, 0, 0, 0); endtask
   task automatic ev(int k, int s);         cycle(0, 0, 0, 0, 1, k, s); endtask
   task automatic idle();                   cycle(0, 0, 0, 0, 0, 0, 0); endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      @(negedge clk);
      cur_req = "R1";
      idle(); idle(); idle();
      rst_n = 1'b1;
      fixed_slots = 32'hFFFF_0000;   // must be ignored after reset (R8)
      for (int a = 0; a < 32; a++) rd(a);

      cur_req = "R2";
      wr('h00, 32'hA5A5_5A5A); rd('h00);
      wr('h04, 32'h0F0F_F0F0); rd('h04); rd('h00);

      cur_req = "R9";
      wr('h12, 32'h0000_0002); wr('h13, 32'hFFFF_FF5A);
      rd('h12); rd('h13); rd('h10); rd('h11);

      cur_req = "R3";
      ev(1, 5); rd('h00); rd('h04); rd('h10);
      ev(1, 0); rd('h00);

      cur_req = "R9";
      wr('h10, 32'h0000_00FD); rd('h10);   // bit 1 not written: stays
      wr('h11, 32'h0000_00FF); rd('h11);
      wr('h10, 32'h0000_0002); rd('h10);

      cur_req = "R4";
      ev(1, 3); ev(2, 31); rd('h00); rd('h04); rd('h10);
      ev(2, 0); rd('h04);

      cur_req = "R5";
      ev(0, 7); rd('h00); rd('h04);
      ev(3, 9); rd('h00); rd('h04);
      wr('h10, 32'h2); ev(0, 4); rd('h10);

      cur_req = "R10";
      ev(1, 12); wr('h12, 32'h0); idle(); wr('h12, 32'h2); idle();
      wr('h10, 32'h2); idle();

      cur_req = "R6";
      wr('h08, 32'h0000_0030); idle();
      wr('h08, 32'h0); idle(); rd('h08);
      wr('h08, 32'h8000_0000); wr('h08, 32'h0000_0001); idle();

      cur_req = "R7";
      wr('h08, 32'h0000_0104); wr('h08, 32'h0000_0100);
      wr('h08, 32'h0000_0200); idle();
      wr('h08, 32'h0001_0000); idle();

      cur_req = "R8";
      rd('h0C); wr('h0C, 32'h0); rd('h0C);

      cur_req = "R11";
      cycle(1, 1, 'h00, 32'hFFFF_FFFF, 1, 1, 6); rd('h00); rd('h04);
      cycle(1, 1, 'h04, 32'hFFFF_FFFF, 1, 2, 17); rd('h00); rd('h04);
      cycle(1, 1, 'h10, 32'h0000_0002, 1, 1, 2); rd('h10);

      cur_req = "R12";
      wr('h14, 32'hFFFF_FFFF); wr('h1F, 32'hFFFF_FFFF);
      rd('h14); rd('h1F); rd('h00); rd('h04); rd('h10); rd('h12);

      summary();
      $finish;
   end

endmodule